// File: doc/BRIEF.md
# Multicycle Instruction Step Controller

This block is the finite-state controller of a multicycle 32-bit processor core that runs a small load/store instruction subset. The four instruction classes are word load, word store, register-to-register ALU operation and branch-on-equal. Every instruction is cut into steps of one clock each: fetch, decode, execute, memory access and register writeback. Each class uses only the steps it needs, so the classes take different numbers of cycles. The controlled datapath has a single memory and a single ALU. Both are shared across the steps through source-select multiplexers that this controller sets.

The controller reads the opcode field (bits [31:26] of the instruction register) and the ALU zero flag. For every cycle it drives the write enables, the memory strobes and the multiplexer selects. The instruction fields that the datapath decodes are rs [25:21], rt [20:16], rd [15:11] and the immediate [15:0]. The register-destination select picks between rt and rd. An opcode outside the subset writes nothing and returns the controller to fetch after decode.

Control bus encodings:
- Address select: 0 = PC, 1 = ALU output register.
- ALU operand A: 0 = PC, 1 = register A.
- ALU operand B: 00 = register B, 01 = constant 4, 10 = sign-extended immediate, 11 = sign-extended immediate shifted left by 2.
- ALU operation: 00 = add, 01 = subtract, 10 = taken from the function field.
- PC source: 0 = live ALU result, 1 = ALU output register.
- Register destination: 0 = rt, 1 = rd.
- Memory-to-register: 1 = the memory data register feeds the register file.

Top module: `mcs_step_ctrl`

## Requirements
- R1: While reset is asserted, and for the one cycle after reset is released, every control output is 0. After that cycle the controller is in fetch.
- R2: Fetch sets these outputs, and every other control is 0:
  - memory read = 1, address select = 0 (PC), instruction-register write = 1, PC write = 1;
  - ALU operand A = 0 (PC), operand B = 01 (constant 4), ALU operation = 00 (add), PC source = 0.
- R3: Decode (the second cycle of every instruction) sets operand A = 0 and operand B = 11, so the branch target is precomputed with ALU operation 00. Every other control is 0, so no write takes place.
- R4: Load (opcode 6'h23) takes 5 cycles. Its steps are:
  - execute: operand A = 1, operand B = 10, add;
  - memory: memory read = 1, address select = 1;
  - writeback: register write = 1, register destination = 0, memory-to-register = 1.
  Every control not listed is 0.
- R5: Store (opcode 6'h2B) takes 4 cycles. Its execute step is the same as the load's. Its last step sets memory write = 1 and address select = 1. It never asserts register write.
- R6: ALU operation (opcode 6'h00) takes 4 cycles. Its steps are:
  - execute: operand A = 1, operand B = 00, ALU operation = 10;
  - writeback: register write = 1, register destination = 1, memory-to-register = 0.
- R7: Branch-on-equal (opcode 6'h04) takes 3 cycles. Its last step sets operand A = 1, operand B = 00, ALU operation = 01 and PC source = 1, with PC write equal to the ALU zero flag.
- R8: Any other opcode takes 2 cycles (fetch, decode) and asserts no write and no memory strobe after fetch.
- R9: Memory read and memory write are never asserted in the same cycle.
- R10: The ALU zero flag has no effect on any output outside the branch's last step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| pc_wr | output | 1 | PC write enable (includes the taken branch) |
| pc_src | output | 1 | PC source: 0 ALU result, 1 ALU output register |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU output register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register write enable |
| reg_dst | output | 1 | Write register: 0 rt, 1 rd |
| mem_to_reg | output | 1 | Register write data: 0 ALU output, 1 memory data |
| reg_wr | output | 1 | Register file write enable |
| alu_src_a | output | 1 | ALU operand A: 0 PC, 1 register A |
| alu_src_b | output | 2 | ALU operand B select (see encodings) |
| alu_op | output | 2 | ALU operation: 00 add, 01 subtract, 10 function field |

## Verification
Each instruction class is run on its own and the whole control vector is compared in every cycle. This separates the load's extra memory and writeback steps from the store's single write and from the ALU path that skips memory. The branch is run once with the zero flag set and once with it clear, which tells a taken branch from a fall-through. The ALU and load instructions are run with the zero flag held high, to show that the flag is ignored outside the branch. Two unrecognised opcodes check the short decode-and-return path. A reset in the middle of a load checks the return to a silent fetch.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_ADDR, ST_LDMEM, ST_LDWB,
    ST_STMEM, ST_ALUEX, ST_ALUWB, ST_BRANCH
  } step_e;

  typedef enum logic [2:0] {
    CL_LOAD, CL_STORE, CL_ALU, CL_BRANCH, CL_OTHER
  } class_e;

  localparam logic [1:0] SRCB_REG    = 2'b00;
  localparam logic [1:0] SRCB_FOUR   = 2'b01;
  localparam logic [1:0] SRCB_IMM    = 2'b10;
  localparam logic [1:0] SRCB_IMM_SH = 2'b11;

  localparam logic [1:0] AOP_ADD   = 2'b00;
  localparam logic [1:0] AOP_SUB   = 2'b01;
  localparam logic [1:0] AOP_FUNCT = 2'b10;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_src;
    logic       addr_sel;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic       reg_dst;
    logic       mem_to_reg;
    logic       reg_wr;
    logic       alu_src_a;
    logic [1:0] alu_src_b;
    logic [1:0] alu_op;
  } ctrl_t;

  // Map an opcode onto its instruction class.
  function automatic class_e classify(input logic [5:0] op,
                                      input logic [5:0] c_ld,
                                      input logic [5:0] c_st,
                                      input logic [5:0] c_alu,
                                      input logic [5:0] c_br);
    if (op == c_ld)       return CL_LOAD;
    else if (op == c_st)  return CL_STORE;
    else if (op == c_alu) return CL_ALU;
    else if (op == c_br)  return CL_BRANCH;
    else                  return CL_OTHER;
  endfunction

  // Number of clock steps an instruction of a class occupies.
  function automatic int unsigned steps_for(input class_e c);
    case (c)
      CL_LOAD:   return 5;
      CL_STORE:  return 4;
      CL_ALU:    return 4;
      CL_BRANCH: return 3;
      default:   return 2;
    endcase
  endfunction

endpackage

// File: rtl/mcs_next_step.sv
module mcs_next_step
  import mcs_pkg::*;
(
  input  step_e  cur,
  input  class_e cls,
  output step_e  nxt
);

  always_comb begin
    nxt = ST_FETCH;
    case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        case (cls)
          CL_LOAD, CL_STORE: nxt = ST_ADDR;
          CL_ALU:            nxt = ST_ALUEX;
          CL_BRANCH:         nxt = ST_BRANCH;
          default:           nxt = ST_FETCH;
        endcase
      end
      ST_ADDR:   nxt = (cls == CL_LOAD) ? ST_LDMEM : ST_STMEM;
      ST_LDMEM:  nxt = ST_LDWB;
      ST_ALUEX:  nxt = ST_ALUWB;
      default:   nxt = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mcs_ctrl_decode.sv
module mcs_ctrl_decode
  import mcs_pkg::*;
(
  input  step_e cur,
  input  logic  alu_zero,
  output ctrl_t ctl
);

  always_comb begin
    ctl = '0;
    case (cur)
      ST_FETCH: begin
        ctl.mem_rd    = 1'b1;
        ctl.ir_wr     = 1'b1;
        ctl.pc_wr     = 1'b1;
        ctl.alu_src_b = SRCB_FOUR;
        ctl.alu_op    = AOP_ADD;
      end
      ST_DECODE: begin
        ctl.alu_src_b = SRCB_IMM_SH;
        ctl.alu_op    = AOP_ADD;
      end
      ST_ADDR: begin
        ctl.alu_src_a = 1'b1;
        ctl.alu_src_b = SRCB_IMM;
        ctl.alu_op    = AOP_ADD;
      end
      ST_LDMEM: begin
        ctl.mem_rd   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      ST_LDWB: begin
        ctl.reg_wr     = 1'b1;
        ctl.mem_to_reg = 1'b1;
      end
      ST_STMEM: begin
        ctl.mem_wr   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      ST_ALUEX: begin
        ctl.alu_src_a = 1'b1;
        ctl.alu_src_b = SRCB_REG;
        ctl.alu_op    = AOP_FUNCT;
      end
      ST_ALUWB: begin
        ctl.reg_wr  = 1'b1;
        ctl.reg_dst = 1'b1;
      end
      ST_BRANCH: begin
        ctl.alu_src_a = 1'b1;
        ctl.alu_src_b = SRCB_REG;
        ctl.alu_op    = AOP_SUB;
        ctl.pc_src    = 1'b1;
        ctl.pc_wr     = alu_zero;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/mcs_step_ctrl.sv
module mcs_step_ctrl
  import mcs_pkg::*;
#(
  parameter int          OPW       = 6,
  parameter logic [5:0]  OP_LOAD   = 6'h23,
  parameter logic [5:0]  OP_STORE  = 6'h2B,
  parameter logic [5:0]  OP_ALU    = 6'h00,
  parameter logic [5:0]  OP_BRANCH = 6'h04,
  parameter int          CNT_W     = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] opcode,
  input  logic           alu_zero,
  output logic           pc_wr,
  output logic           pc_src,
  output logic           addr_sel,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           ir_wr,
  output logic           reg_dst,
  output logic           mem_to_reg,
  output logic           reg_wr,
  output logic           alu_src_a,
  output logic [1:0]     alu_src_b,
  output logic [1:0]     alu_op
);

  step_e  cur_q, nxt;
  class_e cls;
  ctrl_t  raw_ctl, ctl;
  logic   live_q;

  assign cls = classify(opcode, OP_LOAD, OP_STORE, OP_ALU, OP_BRANCH);

  // The first clock after reset only arms the controller; fetch runs after it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      cur_q  <= ST_FETCH;
    end else begin
      live_q <= 1'b1;
      if (live_q) cur_q <= nxt;
    end
  end

  mcs_next_step i_next (
    .cur (cur_q),
    .cls (cls),
    .nxt (nxt)
  );

  mcs_ctrl_decode i_dec (
    .cur      (cur_q),
    .alu_zero (alu_zero),
    .ctl      (raw_ctl)
  );

  assign ctl        = live_q ? raw_ctl : '0;
  assign pc_wr      = ctl.pc_wr;
  assign pc_src     = ctl.pc_src;
  assign addr_sel   = ctl.addr_sel;
  assign mem_rd     = ctl.mem_rd;
  assign mem_wr     = ctl.mem_wr;
  assign ir_wr      = ctl.ir_wr;
  assign reg_dst    = ctl.reg_dst;
  assign mem_to_reg = ctl.mem_to_reg;
  assign reg_wr     = ctl.reg_wr;
  assign alu_src_a  = ctl.alu_src_a;
  assign alu_src_b  = ctl.alu_src_b;
  assign alu_op     = ctl.alu_op;

  // Named events for the assertions.
  logic fetch_evt, decode_evt, branch_evt;
  assign fetch_evt  = live_q && (cur_q == ST_FETCH);
  assign decode_evt = live_q && (cur_q == ST_DECODE);
  assign branch_evt = live_q && (cur_q == ST_BRANCH);

  // Cycle counter between fetches, and the class latched at decode.
  logic [CNT_W-1:0] span_q;
  class_e           cls_q;
  logic             seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      span_q <= '0;
      cls_q  <= CL_OTHER;
      seen_q <= 1'b0;
    end else begin
      span_q <= fetch_evt ? CNT_W'(1) : span_q + CNT_W'(1);
      if (decode_evt) begin
        cls_q  <= cls;
        seen_q <= 1'b1;
      end
    end
  end

  AST_QUIET_ARMING: assert property (@(posedge clk) disable iff (!rst_n)
    !live_q |-> !(pc_wr || ir_wr || mem_rd || mem_wr || reg_wr)) else $error("quiet"); // R1
  AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_evt |=> (cur_q == ST_DECODE)) else $error("fetch"); // R2
  AST_STEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_evt && seen_q) |-> (span_q == CNT_W'(steps_for(cls_q)))) else $error("span"); // R4
  AST_STORE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (addr_sel && !reg_wr)) else $error("store"); // R5
  AST_BRANCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (branch_evt && !alu_zero) |-> !pc_wr) else $error("branch"); // R7
  AST_UNKNOWN_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (decode_evt && cls == CL_OTHER) |=> fetch_evt) else $error("other"); // R8
  AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)) else $error("mem"); // R9
  AST_ZERO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!branch_evt && live_q && !fetch_evt) |-> !pc_wr) else $error("zero"); // R10

endmodule

// File: tb/test_mcs_step_ctrl.sv
module test_mcs_step_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] C_LD = 6'h23, C_ST = 6'h2B, C_ALU = 6'h00, C_BR = 6'h04;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = 6'h3F;
  logic       alu_zero = 1'b0;
  logic       pc_wr, pc_src, addr_sel, mem_rd, mem_wr, ir_wr;
  logic       reg_dst, mem_to_reg, reg_wr, alu_src_a;
  logic [1:0] alu_src_b, alu_op;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcs_step_ctrl i_mcs_step_ctrl (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_zero(alu_zero),
    .pc_wr(pc_wr), .pc_src(pc_src), .addr_sel(addr_sel), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .ir_wr(ir_wr), .reg_dst(reg_dst), .mem_to_reg(mem_to_reg),
    .reg_wr(reg_wr), .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .alu_op(alu_op)
  );

  wire [13:0] obs = {pc_wr, pc_src, addr_sel, mem_rd, mem_wr, ir_wr,
                     reg_dst, mem_to_reg, reg_wr, alu_src_a, alu_src_b, alu_op};

  // Expected control word; field order matches obs.
  function automatic logic [13:0] cw(bit pw, bit ps, bit as, bit mr, bit mw, bit iw,
                                     bit rd, bit m2r, bit rw, bit sa,
                                     logic [1:0] sb, logic [1:0] op);
    return {pw, ps, as, mr, mw, iw, rd, m2r, rw, sa, sb, op};
  endfunction

  logic [13:0] V_ZERO, V_FETCH, V_DEC, V_ADDR, V_LDMEM, V_LDWB, V_STMEM, V_AEX, V_AWB;

  initial begin
    V_ZERO  = '0;
    V_FETCH = cw(1,0,0,1,0,1,0,0,0,0,2'b01,2'b00);
    V_DEC   = cw(0,0,0,0,0,0,0,0,0,0,2'b11,2'b00);
    V_ADDR  = cw(0,0,0,0,0,0,0,0,0,1,2'b10,2'b00);
    V_LDMEM = cw(0,0,1,1,0,0,0,0,0,0,2'b00,2'b00);
    V_LDWB  = cw(0,0,0,0,0,0,0,1,1,0,2'b00,2'b00);
    V_STMEM = cw(0,0,1,0,1,0,0,0,0,0,2'b00,2'b00);
    V_AEX   = cw(0,0,0,0,0,0,0,0,0,1,2'b00,2'b10);
    V_AWB   = cw(0,0,0,0,0,0,1,0,1,0,2'b00,2'b00);
  end

  function automatic logic [13:0] v_branch(bit z);
    return cw(z,1,0,0,0,0,0,0,0,1,2'b00,2'b01);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // Runs one instruction starting at a fetch sample point and checks every cycle.
  task automatic run_instr(input string tag, input logic [5:0] op, input bit z,
                           input int n, input logic [13:0] seq [5]);
    opcode   = op;
    alu_zero = z;
    for (int k = 0; k < n; k++) begin
      string req;
      req = (k == 0) ? "R2" : (k == 1) ? "R3" : tag;
      check(obs == seq[k], req, $sformatf("%s step %0d", tag, k), obs, seq[k]);
      check(!(mem_rd && mem_wr), "R9", "read and write together", {12'd0, mem_rd, mem_wr}, 14'd0);
      step();
    end
    check(obs == V_FETCH, tag, $sformatf("%s back in fetch after %0d cycles", tag, n), obs, V_FETCH);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      check(obs == V_ZERO, "R1", "outputs during reset", obs, V_ZERO);
    end
    rst_n = 1'b1;
    #1;
    check(obs == V_ZERO, "R1", "arming cycle after release", obs, V_ZERO);
    step();
    check(obs == V_FETCH, "R1", "first fetch after reset", obs, V_FETCH);
  endtask

  task automatic t_load(input bit z, input string tag);
    run_instr(tag, C_LD, z, 5, '{V_FETCH, V_DEC, V_ADDR, V_LDMEM, V_LDWB});
  endtask

  task automatic t_store();
    run_instr("R5", C_ST, 1'b0, 4, '{V_FETCH, V_DEC, V_ADDR, V_STMEM, V_ZERO});
  endtask

  task automatic t_alu(input bit z, input string tag);
    run_instr(tag, C_ALU, z, 4, '{V_FETCH, V_DEC, V_AEX, V_AWB, V_ZERO});
  endtask

  task automatic t_branch(input bit z);
    run_instr("R7", C_BR, z, 3, '{V_FETCH, V_DEC, v_branch(z), V_ZERO, V_ZERO});
  endtask

  task automatic t_unknown(input logic [5:0] op);
    run_instr("R8", op, 1'b1, 2, '{V_FETCH, V_DEC, V_ZERO, V_ZERO, V_ZERO});
  endtask

  task automatic t_reset_mid();
    opcode = C_LD;
    step();
    step();
    rst_n = 1'b0;
    #1;
    check(obs == V_ZERO, "R1", "reset during load", obs, V_ZERO);
    step();
    rst_n = 1'b1;
    #1;
    check(obs == V_ZERO, "R1", "arming after mid reset", obs, V_ZERO);
    step();
    check(obs == V_FETCH, "R1", "fetch after mid reset", obs, V_FETCH);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    t_load(1'b0, "R4");
    t_store();
    t_alu(1'b0, "R6");
    t_branch(1'b1);
    t_branch(1'b0);
    t_unknown(6'h3F);
    t_unknown(6'h02);
    t_alu(1'b1, "R10");
    t_load(1'b1, "R10");
    t_reset_mid();
    t_store();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule